// File: doc/BRIEF.md
# Streaming 32-bit effective address generator

This block turns the operand-address bytes of an instruction into a 32-bit memory offset. The bytes come in one per accepted cycle: first the ModR/M byte, then an optional SIB byte, then an optional displacement of one or four bytes. While it works, the block drives two register-select lines into the general register file and reads the two 32-bit values that come back in the same cycle. After the last byte of an operand it emits the offset once, together with the number of bytes it consumed.

The decoder upstream feeds the bytes that follow the opcode. It can insert idle cycles between bytes at any point, and it can start the next operand in the cycle right after the previous one ends. Segment choice, the 16-bit forms and register-direct operands belong to other blocks. A ModR/M byte that selects a register-direct operand is dropped here.

Top module: `sib_ea_gen`

## Requirements
- R1: After reset, `ea_vld` is low and the next accepted byte is taken as a ModR/M byte.
- R2: For a ModR/M byte with mod=00 and rm not 4 or 5, the result is register[rm] with length 1. `ea_vld` rises in the cycle after the byte is accepted. ModR/M fields: mod in bits 7:6, rm in bits 2:0.
- R3: For mod=00 with rm=5, the four bytes that follow are a 32-bit displacement, least significant byte first. The result is that displacement alone, with length 5.
- R4: With rm not 4, mod=01 adds a sign-extended 8-bit displacement to register[rm] (length 2) and mod=10 adds a 32-bit displacement (length 5). With rm=5 in these modes the base is register 5.
- R5: rm=4 means a SIB byte follows. Its fields are scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The offset is register[base] plus register[index] shifted left by scale, so it is scaled by 1, 2, 4 or 8 and never by the index number.
- R6: An index field of 4 adds nothing, whatever the scale.
- R7: With a SIB base of 5 and mod=00, no base register is used. A 32-bit displacement follows the SIB byte and no second displacement is read (length 6).
- R8: With a SIB byte and mod=01 or mod=10, the displacement (8-bit sign-extended or 32-bit) follows the SIB byte, and a base of 5 selects register 5 (length 3 or 6).
- R9: Every sum wraps modulo 2^32.
- R10: A cycle with `byte_vld` low changes no decoding state, so idle cycles between bytes do not change the result.
- R11: A ModR/M byte with mod=11 produces no result, and the next accepted byte is again taken as a ModR/M byte.
- R12: The first byte of the next operand can be accepted in the same cycle that `ea_vld` reports the previous operand, with no lost or extra results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | `byte_in` is valid and is consumed this cycle |
| byte_in | input | 8 | Next operand-address byte |
| rf_base_sel | output | 3 | Register-file select for the base value |
| rf_base_val | input | 32 | Register value for `rf_base_sel`, same cycle |
| rf_idx_sel | output | 3 | Register-file select for the index value |
| rf_idx_val | input | 32 | Register value for `rf_idx_sel`, same cycle |
| ea_vld | output | 1 | One-cycle pulse: a new offset is on `ea_offset` |
| ea_offset | output | 32 | Computed effective offset |
| ea_len | output | 3 | Bytes consumed for this operand (1 to 6) |

## Verification
The two functions that share a cycle are the completion of one operand, when its sum is registered onto `ea_offset`, and the acceptance of the ModR/M byte of the next operand. In that cycle the register selects switch from the stored fields to the new byte. The bench streams operands back to back with no gap and also with idle cycles between bytes. It mixes every escape (SIB, no base, no index) so that each completion is followed at once by a differently shaped operand. A scoreboard queue holds, in order, the offset and length worked out from the requirements for each operand. Any missing, extra or wrong pulse is reported against the requirement that operand exercises.

// File: rtl/sib_ea_pkg.sv
package sib_ea_pkg;
    localparam int EA_W   = 32;
    localparam int NREG   = 8;
    localparam int SEL_W  = $clog2(NREG);
    localparam int LEN_W  = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(EA_W / BYTE_W);

    localparam logic [SEL_W-1:0] CODE_SIB_ESC  = 3'd4;
    localparam logic [SEL_W-1:0] CODE_NO_BASE  = 3'd5;
    localparam logic [SEL_W-1:0] CODE_NO_INDEX = 3'd4;

    typedef enum logic [1:0] {
        PH_MODRM = 2'd0,
        PH_SIB   = 2'd1,
        PH_DISP  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        DK_NONE = 2'd0,
        DK_BYTE = 2'd1,
        DK_WORD = 2'd2
    } disp_kind_e;

    typedef struct packed {
        phase_e             phase;
        logic [1:0]         mode;
        logic               use_base;
        logic               use_idx;
        logic [SEL_W-1:0]   base_sel;
        logic [SEL_W-1:0]   idx_sel;
        logic [1:0]         scale;
        logic [EA_W-1:0]    disp;
        logic [CNT_W-1:0]   disp_cnt;
        logic               disp_wide;
        logic [LEN_W-1:0]   used;
        logic               out_vld;
        logic [EA_W-1:0]    out_ea;
        logic [LEN_W-1:0]   out_len;
    } ctx_t;
endpackage

// File: rtl/sib_ea_modes.sv
module sib_ea_modes
    import sib_ea_pkg::*;
(
    input  logic              sib_phase,
    input  logic [1:0]        mode_held,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              ignore,
    output logic              need_sib,
    output logic              use_base,
    output logic              use_idx,
    output logic [SEL_W-1:0]  base_sel,
    output logic [SEL_W-1:0]  idx_sel,
    output logic [1:0]        scale,
    output disp_kind_e        dkind
);
    logic [1:0] mode_eff;
    logic       no_base;

    always_comb begin
        // The mode field lives in the ModR/M byte; in the SIB phase it is the held copy.
        mode_eff = sib_phase ? mode_held : byte_in[7:6];
        base_sel = byte_in[2:0];
        ignore   = !sib_phase && (byte_in[7:6] == 2'b11);
        need_sib = !sib_phase && !ignore && (byte_in[2:0] == CODE_SIB_ESC);
        use_idx  = sib_phase && (byte_in[5:3] != CODE_NO_INDEX);
        idx_sel  = sib_phase ? byte_in[5:3] : '0;
        scale    = sib_phase ? byte_in[7:6] : 2'b00;
        // Same escape in both bytes: field value 5 with mode 00 drops the base.
        no_base  = (mode_eff == 2'b00) && (byte_in[2:0] == CODE_NO_BASE);
        use_base = !no_base;
        if (mode_eff == 2'b01)      dkind = DK_BYTE;
        else if (mode_eff == 2'b10) dkind = DK_WORD;
        else if (no_base)           dkind = DK_WORD;
        else                        dkind = DK_NONE;
    end
endmodule

// File: rtl/sib_ea_adder.sv
module sib_ea_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] base_val,
    input  logic         use_base,
    input  logic [W-1:0] idx_val,
    input  logic         use_idx,
    input  logic [1:0]   scale,
    input  logic [W-1:0] disp,
    output logic [W-1:0] sum
);
    logic [W-1:0] base_term;
    logic [W-1:0] idx_term;

    always_comb begin
        base_term = use_base ? base_val : '0;
        idx_term  = use_idx ? (idx_val << scale) : '0;
        sum       = base_term + idx_term + disp;
    end
endmodule

// File: rtl/sib_ea_gen.sv
module sib_ea_gen
    import sib_ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [SEL_W-1:0]  rf_base_sel,
    input  logic [EA_W-1:0]   rf_base_val,
    output logic [SEL_W-1:0]  rf_idx_sel,
    input  logic [EA_W-1:0]   rf_idx_val,
    output logic              ea_vld,
    output logic [EA_W-1:0]   ea_offset,
    output logic [LEN_W-1:0]  ea_len
);
    localparam int LAST_WIDE = (EA_W / BYTE_W) - 1;

    ctx_t q, d;

    logic             m_ignore, m_need_sib, m_use_base, m_use_idx;
    logic [SEL_W-1:0] m_base_sel, m_idx_sel;
    logic [1:0]       m_scale;
    disp_kind_e       m_dkind;

    logic             in_disp;
    logic             a_use_base, a_use_idx;
    logic [1:0]       a_scale;
    logic [EA_W-1:0]  disp_acc, disp_fin, a_disp, ea_sum;
    logic             disp_last;

    sib_ea_modes modes_i (
        .sib_phase (q.phase == PH_SIB),
        .mode_held (q.mode),
        .byte_in   (byte_in),
        .ignore    (m_ignore),
        .need_sib  (m_need_sib),
        .use_base  (m_use_base),
        .use_idx   (m_use_idx),
        .base_sel  (m_base_sel),
        .idx_sel   (m_idx_sel),
        .scale     (m_scale),
        .dkind     (m_dkind)
    );

    sib_ea_adder #(.W(EA_W)) adder_i (
        .base_val (rf_base_val),
        .use_base (a_use_base),
        .idx_val  (rf_idx_val),
        .use_idx  (a_use_idx),
        .scale    (a_scale),
        .disp     (a_disp),
        .sum      (ea_sum)
    );

    // Operand path: from the live byte in the decode phases, from stored fields during the displacement.
    always_comb begin
        in_disp     = (q.phase == PH_DISP);
        disp_acc    = q.disp | ({{(EA_W-BYTE_W){1'b0}}, byte_in} << {q.disp_cnt, 3'b000});
        disp_last   = q.disp_wide ? (q.disp_cnt == CNT_W'(LAST_WIDE)) : 1'b1;
        disp_fin    = q.disp_wide ? disp_acc : {{(EA_W-BYTE_W){byte_in[BYTE_W-1]}}, byte_in};
        rf_base_sel = in_disp ? q.base_sel : m_base_sel;
        rf_idx_sel  = in_disp ? q.idx_sel  : m_idx_sel;
        a_use_base  = in_disp ? q.use_base : m_use_base;
        a_use_idx   = in_disp ? q.use_idx  : m_use_idx;
        a_scale     = in_disp ? q.scale    : m_scale;
        a_disp      = in_disp ? disp_fin   : '0;
    end

    always_comb begin
        d         = q;
        d.out_vld = 1'b0;
        if (byte_vld) begin
            unique case (q.phase)
                PH_MODRM: begin
                    if (!m_ignore) begin
                        d.mode      = byte_in[7:6];
                        d.used      = LEN_W'(1);
                        d.use_base  = m_use_base;
                        d.base_sel  = m_base_sel;
                        d.use_idx   = 1'b0;
                        d.idx_sel   = '0;
                        d.scale     = 2'b00;
                        d.disp      = '0;
                        d.disp_cnt  = '0;
                        d.disp_wide = (m_dkind == DK_WORD);
                        if (m_need_sib) begin
                            d.phase = PH_SIB;
                        end else if (m_dkind != DK_NONE) begin
                            d.phase = PH_DISP;
                        end else begin
                            d.out_vld = 1'b1;
                            d.out_ea  = ea_sum;
                            d.out_len = LEN_W'(1);
                        end
                    end
                end
                PH_SIB: begin
                    d.used      = LEN_W'(2);
                    d.use_base  = m_use_base;
                    d.base_sel  = m_base_sel;
                    d.use_idx   = m_use_idx;
                    d.idx_sel   = m_idx_sel;
                    d.scale     = m_scale;
                    d.disp_wide = (m_dkind == DK_WORD);
                    if (m_dkind != DK_NONE) begin
                        d.phase = PH_DISP;
                    end else begin
                        d.phase   = PH_MODRM;
                        d.out_vld = 1'b1;
                        d.out_ea  = ea_sum;
                        d.out_len = LEN_W'(2);
                    end
                end
                PH_DISP: begin
                    d.used     = q.used + LEN_W'(1);
                    d.disp     = disp_acc;
                    d.disp_cnt = q.disp_cnt + CNT_W'(1);
                    if (disp_last) begin
                        d.phase   = PH_MODRM;
                        d.out_vld = 1'b1;
                        d.out_ea  = ea_sum;
                        d.out_len = q.used + LEN_W'(1);
                    end
                end
                default: d.phase = PH_MODRM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ea_vld    = q.out_vld;
    assign ea_offset = q.out_ea;
    assign ea_len    = q.out_len;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(q.phase) && !ea_vld);

    // R12
    result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_vld |-> $past(byte_vld));

    // R11
    modrm_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_MODRM && byte_vld && byte_in[7:6] == 2'b11) |=> !ea_vld && q.phase == PH_MODRM);

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_vld |-> (ea_len >= LEN_W'(1)) && (ea_len <= LEN_W'(6)));

    // R3
    disp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_DISP && !q.disp_wide) |-> q.disp_cnt == '0);
endmodule

// File: tb/sib_ea_gen_tb.sv
`timescale 1ns/1ps
module sib_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [2:0]  rf_base_sel, rf_idx_sel;
    logic [31:0] rf_base_val, rf_idx_val;
    logic        ea_vld;
    logic [31:0] ea_offset;
    logic [2:0]  ea_len;

    logic [31:0] regs [8];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_off_q [$];
    int          exp_len_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    assign rf_base_val = regs[rf_base_sel];
    assign rf_idx_val  = regs[rf_idx_sel];

    sib_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .rf_base_sel(rf_base_sel), .rf_base_val(rf_base_val),
        .rf_idx_sel(rf_idx_sel), .rf_idx_val(rf_idx_val),
        .ea_vld(ea_vld), .ea_offset(ea_offset), .ea_len(ea_len)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Reference built from the requirement text.
    function automatic void ref_ea(input logic [47:0] s, output logic [31:0] off, output int n);
        logic [1:0]  m;
        logic [2:0]  rm;
        logic [7:0]  sb;
        logic [31:0] b, ix, dsp;
        int p, dl;
        m = s[7:6]; rm = s[2:0]; p = 1; dl = 0; b = 0; ix = 0; dsp = 0;
        if (rm == 3'd4) begin
            sb = s[15:8]; p = 2;
            if (sb[5:3] != 3'd4) ix = regs[sb[5:3]] << sb[7:6];
            if (sb[2:0] == 3'd5 && m == 2'b00) dl = 4;
            else begin
                b  = regs[sb[2:0]];
                dl = (m == 2'b01) ? 1 : (m == 2'b10) ? 4 : 0;
            end
        end else if (m == 2'b00 && rm == 3'd5) begin
            dl = 4;
        end else begin
            b  = regs[rm];
            dl = (m == 2'b01) ? 1 : (m == 2'b10) ? 4 : 0;
        end
        if (dl == 1) dsp = {{24{s[8*p+7]}}, s[8*p +: 8]};
        else if (dl == 4) dsp = s[8*p +: 32];
        off = b + ix + dsp;
        n   = p + dl;
    endfunction

    task automatic send(input logic [47:0] s, input string tag, input int gap);
        logic [31:0] off;
        int n;
        ref_ea(s, off, n);
        exp_off_q.push_back(off);
        exp_len_q.push_back(n);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_in  = s[8*i +: 8];
            if (i < n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    byte_vld = 1'b0;
                    byte_in  = 8'hC4;
                end
            end
        end
        @(posedge clk);
        #1;
        byte_vld = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && ea_vld) begin
            if (tag_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R12 unexpected result actual=%0h expected=none", ea_offset);
            end else begin
                chk({tag_q[0], " offset"}, {32'h0, ea_offset}, {32'h0, exp_off_q[0]});
                chk({tag_q[0], " length"}, {61'h0, ea_len}, 64'(exp_len_q[0]));
                void'(tag_q.pop_front());
                void'(exp_off_q.pop_front());
                void'(exp_len_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0200;
        regs[2] = 32'h0003_0000; regs[3] = 32'h0400_0000;
        regs[4] = 32'h0000_0050; regs[5] = 32'h0060_0000;
        regs[6] = 32'h0000_0007; regs[7] = 32'h8000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {63'h0, ea_vld}, 64'h0);

        // R2 plain register forms
        send(48'h00, "R2 mod0 rm0", 0);
        send(48'h03, "R2 mod0 rm3", 0);
        send(48'h07, "R2 mod0 rm7", 0);
        // R3 displacement only
        send({8'h0, 32'h1234_5678, 8'h05}, "R3 disp32 only", 0);
        // R4 register plus displacement
        send({32'h0, 8'hF0, 8'h41}, "R4 mod1 negative disp8", 0);
        send({32'h0, 8'h7F, 8'h45}, "R4 mod1 rm5 reg5 base", 0);
        send({8'h0, 32'hCAFE_0000, 8'h86}, "R4 mod2 disp32", 0);
        // R5 SIB scaled index
        send({32'h0, 8'h88, 8'h04}, "R5 scale4 idx1 base0", 0);
        send({32'h0, 8'hF3, 8'h04}, "R5 scale8 idx6 base3", 0);
        send({32'h0, 8'h14, 8'h04}, "R5 scale1 base4", 0);
        // R6 no index
        send({32'h0, 8'hE1, 8'h04}, "R6 index4 scale8", 0);
        // R7 SIB with no base, single displacement
        send({32'h0000_1111, 8'h55, 8'h04}, "R7 nobase scaled idx", 0);
        send({32'hA5A5_0001, 8'h25, 8'h04}, "R7 nobase no index", 0);
        // R8 SIB followed by displacement
        send({24'h0, 8'h80, 8'h75, 8'h44}, "R8 mod1 base5 disp8", 0);
        send({32'h0000_0100, 8'h88, 8'h84}, "R8 mod2 disp32", 0);
        // R9 wrap
        send({32'h0, 8'h7F, 8'h04}, "R9 wrap scaled", 0);
        send({8'h0, 32'h8000_0010, 8'h87}, "R9 wrap disp32", 0);
        regs[2] = 32'hFFFF_FFF0;
        send({32'h0, 8'h20, 8'h42}, "R9 wrap disp8", 0);
        // R10 idle cycles between bytes
        send({32'h0000_1111, 8'h55, 8'h04}, "R10 gaps nobase", 2);
        send({24'h0, 8'h80, 8'h75, 8'h44}, "R10 gaps disp8", 3);
        send({8'h0, 32'h1234_5678, 8'h05}, "R10 gaps disp32", 1);
        // R11 register-direct byte dropped
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = 8'hC4;
        @(negedge clk);
        byte_vld = 1'b0;
        chk("R11 no result for mod3", {63'h0, ea_vld}, 64'h0);
        send(48'h00, "R11 next byte is ModR/M", 0);
        // R12 back-to-back with changed registers
        regs[0] = 32'h1357_9BDF; regs[6] = 32'h0000_0100;
        send(48'h06, "R12 b2b a", 0);
        send({32'h0, 8'hB0, 8'h04}, "R12 b2b b", 0);
        send(48'h00, "R12 b2b c", 0);
        send({8'h0, 32'h0000_0004, 8'h80}, "R12 b2b d", 0);
        repeat (4) @(negedge clk);
        chk("R12 all results delivered", 64'(tag_q.size()), 64'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule